// File: doc/BRIEF.md
# Word-Serial Montgomery Multiplier (Prime Field)

This block computes the Montgomery product of two residues modulo an odd
modulus. It walks the multiplier operand one bit per outer pass, starting
from the least significant bit. Within each pass it streams the multiplicand,
the modulus and a running accumulator through a single word-wide adder, one
word per clock. The low bit of the first word sum of each pass decides
whether the modulus is folded in. The accumulator is halved as its words are
produced: each new word lends its bottom bit to the top of the word below it.

A caller drives the three operands and pulses `start`. When the result is
ready, `done` is high for one cycle. After the last pass the accumulator is
compared against the modulus and reduced at most once. The result stays on
`product` until the next operation completes. The operand width is
`W*E` bits, set by the word width and the word count.

Top module: `montgomery_word_mul`

## Requirements
- R1: While reset is held and in the first cycle after it, `done` is 0 and `product` is 0.
- R2: For an odd modulus p with 3 <= p < 2^(n-1), n = W*E, and operands A, B < p, the result satisfies result * 2^n == A*B (mod p). Bit i of A is consumed in pass i, from bit 0 upward.
- R3: The closing step subtracts p only when the accumulator is strictly greater than p. The result therefore lies in [0, p]. It equals p exactly when p divides A*B and A*B > 0, for example p = 15, A = 3, B = 5.
- R4: `done` rises W*E*... more precisely n*E + 1 clock edges after the edge that samples an accepted `start`, and stays high for exactly one cycle.
- R5: A `start` pulse while an operation is in progress, including its closing cycle, is ignored. The running operation's operands and result are unaffected.
- R6: `product` changes only on the edge that raises `done`, and holds its value in between.
- R7: A = 0 yields a result of 0 for any B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| op_a | input | W*E | Multiplier A, scanned bit by bit |
| op_b | input | W*E | Multiplicand B |
| modulus | input | W*E | Odd modulus p |
| product | output | W*E | Montgomery product, held until the next completion |
| done | output | 1 | One-cycle pulse when `product` is updated |

## Verification
The only result of an operation is the `product`/`done` pair. It is due n*E + 1 edges after the accepting edge, which is 65 edges with the default 4-bit words and four words.

The bench keeps a behavioural countdown that starts on each start it judges acceptable. The countdown ignores starts seen while it is still counting. On the edge where it reaches zero, the bench predicts the pulse and the arithmetic value. Between those edges it predicts a quiet `done` and an unchanged `product`.

Both outputs are compared on the falling edge of every clock. A late or early result, a dropped busy-time start, or a drifting output shows up on the exact cycle it occurs.

// File: rtl/mwm_pkg.sv
// Shared types for the word-serial Montgomery multiplier.
package mwm_pkg;
    // Sequencer phases: waiting, word-serial passes, closing reduction.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/mwm_word_pe.sv
// One word slice of a Montgomery pass.
// It adds a_bit*B(j) + T(j) + q*p(j) + carry. On the first word of a pass
// (first=1) the reduction flag q is the low bit of a_bit*B(0)+T(0), and the
// incoming carry is ignored. On later words q comes from q_hold.
// Assumes W >= 2. The carry out never exceeds 2, so it fits in two bits.
module mwm_word_pe #(
    parameter int W = 4
) (
    input  logic         a_bit,
    input  logic         first,
    input  logic         q_hold,
    input  logic [W-1:0] b_wd,
    input  logic [W-1:0] t_wd,
    input  logic [W-1:0] p_wd,
    input  logic [1:0]   c_in,
    output logic         q_now,
    output logic [W-1:0] s_wd,
    output logic [1:0]   c_out
);
    localparam int SW = W + 2;

    logic [SW-1:0] ab_sum;
    logic [SW-1:0] full;

    // Word sum with the reduction flag picked from the partial sum or held.
    always_comb begin
        ab_sum = {2'b00, t_wd} + (a_bit ? {2'b00, b_wd} : '0);
        q_now  = first ? ab_sum[0] : q_hold;
        full   = ab_sum + (q_now ? {2'b00, p_wd} : '0)
                        + (first ? '0 : {{W{1'b0}}, c_in});
    end

    assign s_wd  = full[W-1:0];
    assign c_out = full[SW-1:W];
endmodule

// File: rtl/mwm_seq_ctrl.sv
// Sequencer for the word-serial Montgomery multiplier.
// It accepts start only when idle, then steps the word index 0..E-1 within
// each of NB passes. After the last word of the last pass it spends one
// closing cycle in SEQ_FIN. Assumes NB >= 2 and E >= 1.
module mwm_seq_ctrl
    import mwm_pkg::*;
#(
    parameter int E  = 4,
    parameter int NB = 16,
    localparam int IW = (E > 1) ? $clog2(E) : 1,
    localparam int BW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          load,
    output logic          run,
    output logic          fin,
    output logic          busy,
    output logic [IW-1:0] wrd,
    output logic          first_w,
    output logic          last_w
);
    seq_state_t    state_q;
    logic [BW-1:0] pass_q;
    logic [IW-1:0] wrd_q;

    // Phase, word index and pass counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            wrd_q   <= '0;
            pass_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: if (start) begin
                    state_q <= SEQ_RUN;
                    wrd_q   <= '0;
                    pass_q  <= '0;
                end
                SEQ_RUN: if (last_w) begin
                    wrd_q <= '0;
                    if (pass_q == BW'(NB - 1)) state_q <= SEQ_FIN;
                    else                       pass_q  <= pass_q + 1'b1;
                end else begin
                    wrd_q <= wrd_q + 1'b1;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign load    = (state_q == SEQ_IDLE) && start;
    assign run     = (state_q == SEQ_RUN);
    assign fin     = (state_q == SEQ_FIN);
    assign busy    = (state_q != SEQ_IDLE);
    assign wrd     = wrd_q;
    assign first_w = (wrd_q == '0);
    assign last_w  = (wrd_q == IW'(E - 1));
endmodule

// File: rtl/montgomery_word_mul.sv
// Word-serial Montgomery multiplier: product = A*B*2^-n mod p, n = W*E.
// Each pass consumes one bit of A and spends E cycles, one per word.
// Word j-1 of the accumulator is rewritten when word j appears, taking that
// word's low bit as its top bit. The top word receives the final carry.
// Assumes p odd, p < 2^(n-1), A and B < p, and W >= 2.
module montgomery_word_mul #(
    parameter int W = 4,
    parameter int E = 4,
    localparam int N  = W * E,
    localparam int IW = (E > 1) ? $clog2(E) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic [N-1:0] modulus,
    output logic [N-1:0] product,
    output logic         done
);
    logic          load, run, fin, busy, first_w, last_w;
    logic [IW-1:0] wrd, prev_w;
    logic [N-1:0]  a_sh, b_q, p_q, t_q;
    logic [W-1:0]  hold_q, s_wd;
    logic [1:0]    c_q, c_out;
    logic          q_q, q_now;

    mwm_seq_ctrl #(.E(E), .NB(N)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load(load), .run(run), .fin(fin), .busy(busy),
        .wrd(wrd), .first_w(first_w), .last_w(last_w)
    );

    assign prev_w = wrd - IW'(1);

    mwm_word_pe #(.W(W)) pe_i (
        .a_bit(a_sh[0]), .first(first_w), .q_hold(q_q),
        .b_wd(b_q[int'(wrd)*W +: W]),
        .t_wd(t_q[int'(wrd)*W +: W]),
        .p_wd(p_q[int'(wrd)*W +: W]),
        .c_in(c_q), .q_now(q_now), .s_wd(s_wd), .c_out(c_out)
    );

    // Capture operands on accept; step the multiplier bit after each pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_sh <= '0;
            b_q  <= '0;
            p_q  <= '0;
        end else if (load) begin
            a_sh <= op_a;
            b_q  <= op_b;
            p_q  <= modulus;
        end else if (run && last_w) begin
            a_sh <= a_sh >> 1;
        end
    end

    // Accumulator: clear on accept, write shifted words as they form.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            t_q <= '0;
        end else if (run) begin
            if (!first_w)
                t_q[int'(prev_w)*W +: W] <= {s_wd[0], hold_q[W-1:1]};
            if (last_w)
                t_q[int'(wrd)*W +: W] <= {c_out[0], s_wd[W-1:1]};
        end
    end

    // Per-word state carried between cycles of a pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            c_q    <= '0;
            q_q    <= 1'b0;
        end else if (run) begin
            hold_q <= s_wd;
            c_q    <= c_out;
            if (first_w) q_q <= q_now;
        end
    end

    // Closing conditional subtraction and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            product <= '0;
            done    <= 1'b0;
        end else begin
            done <= fin;
            if (fin) product <= (t_q > p_q) ? (t_q - p_q) : t_q;
        end
    end
endmodule

// File: rtl/mwm_check.sv
// Protocol and range checks for montgomery_word_mul, attached by bind.
// An edge counter measures latency, so no long $past window is needed.
module mwm_check #(
    parameter int N = 16,
    parameter int E = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         done,
    input logic         busy,
    input logic         load,
    input logic [N-1:0] product,
    input logic [N-1:0] p_q,
    input logic [N-1:0] b_q
);
    int lat_q;

    // Edges elapsed since the accepting edge, counted from 1.
    always_ff @(posedge clk) begin
        if (!rst_n)              lat_q <= 0;
        else if (load)           lat_q <= 1;
        else if (done)           lat_q <= 0;
        else if (lat_q != 0)     lat_q <= lat_q + 1;
    end

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == N * E + 2));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product <= p_q));

    assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(b_q) && $stable(p_q)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(product) |-> done);
endmodule

bind montgomery_word_mul mwm_check #(.N(N), .E(E)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .busy(busy),
    .load(load), .product(product), .p_q(p_q), .b_q(b_q)
);

// File: tb/montgomery_word_mul_tb_top.sv
// Bench: a behavioural countdown model predicts done/product every cycle.
module montgomery_word_mul_tb_top;
    localparam int W   = 4;
    localparam int E   = 4;
    localparam int N   = W * E;
    localparam int LAT = N * E + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] op_a = '0, op_b = '0, modulus = '0;
    logic [N-1:0] product;
    logic         done;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R2";
    bit    live = 1'b0;

    // Model state
    bit     m_busy = 1'b0;
    int     m_rem = 0;
    bit     exp_done = 1'b0;
    longint exp_prod = 0;
    longint pend = 0;

    always #10 clk = ~clk;

    montgomery_word_mul #(.W(W), .E(E)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .modulus(modulus), .product(product), .done(done)
    );

    // Bit-serial integer form of A*B*2^-n mod p with a greater-than reduction.
    function automatic longint mont_ref(longint a, longint b, longint p);
        longint t = 0;
        for (int i = 0; i < N; i++) begin
            if ((a >> i) & 1) t = t + b;
            if (t & 1) t = t + p;
            t = t >> 1;
        end
        if (t > p) t = t - p;
        return t;
    endfunction

    // Reference countdown, updated on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_rem = 0; exp_done = 1'b0; exp_prod = 0;
        end else begin
            exp_done = 1'b0;
            if (m_busy) begin
                m_rem = m_rem - 1;
                if (m_rem == 0) begin
                    exp_done = 1'b1; exp_prod = pend; m_busy = 1'b0;
                end
            end else if (start) begin
                m_busy = 1'b1; m_rem = LAT;
                pend = mont_ref(longint'(op_a), longint'(op_b), longint'(modulus));
            end
        end
    end

    // Compare on every falling edge (R4 timing, R6 hold, value per cur_req).
    always @(negedge clk) begin
        if (live) begin
            n_chk++;
            if (done !== exp_done) begin
                n_bad++;
                $display("FAIL R4 done: actual %0b expected %0b at %0t", done, exp_done, $time);
            end
            if (product !== N'(exp_prod)) begin
                n_bad++;
                $display("FAIL %s/R6 product: actual %0d expected %0d at %0t",
                         cur_req, product, exp_prod, $time);
            end
        end
    end

    task automatic run_op(input longint a, input longint b, input longint p, input string req);
        @(negedge clk);
        cur_req = req;
        op_a = N'(a); op_b = N'(b); modulus = N'(p); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (LAT + 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;  // R1 reset state
        if (done !== 1'b0 || product !== '0) begin
            n_bad++;
            $display("FAIL R1 reset: actual done=%0b product=%0d expected 0/0", done, product);
        end
        rst_n = 1'b1;
        live = 1'b1;

        run_op(0, 100, 101, "R7");              // R7: A = 0
        run_op(0, 32766, 32767, "R7");
        run_op(100, 100, 101, "R2");            // R2: A = B = p-1
        run_op(1, 1, 3, "R2");
        run_op(3, 5, 15, "R3");                 // R3: result equals p (15)
        run_op(5, 9, 15, "R3");
        run_op(32766, 32766, 32767, "R2");
        for (int k = 0; k < 24; k++) begin
            longint p, a, b;
            p = longint'($urandom % (1 << (N - 1))) | 1;
            if (p < 3) p = 3;
            a = longint'($urandom) % p;
            b = longint'($urandom) % p;
            run_op(a, b, p, "R2");
        end

        // R5: a second start mid-run with other operands must be ignored.
        @(negedge clk);
        cur_req = "R5";
        op_a = 16'd1234; op_b = 16'd4321; modulus = 16'd30001; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        op_a = 16'd7; op_b = 16'd8; modulus = 16'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (LAT) @(negedge clk);

        // R4: start held through the done cycle is taken right after it.
        @(negedge clk);
        cur_req = "R4";
        op_a = 16'd222; op_b = 16'd333; modulus = 16'd1001; start = 1'b1;
        repeat (2 * LAT + 4) @(negedge clk);
        start = 1'b0;
        repeat (LAT + 2) @(negedge clk);

        live = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule